// File: doc/BRIEF.md
# Level-Sensitive Interrupt Controller with Register Port

This block collects a set of level-sensitive interrupt sources, grouped in banks of 32, and presents at most one of them at a time to a processor. Each source can be masked. Software sets mask bits through a write-one-to-set register and clears them through a write-one-to-clear register. A status register per bank shows which sources are both asserted and unmasked.

When anything is pending and nothing is being presented, the controller latches the lowest-numbered pending source. It then raises its request output and drives that source number. The selection stays frozen until software writes the acknowledge bit. On the cycle after the acknowledge, the controller picks again from whatever is pending.

A system configuration register carries an autoidle bit and a self-clearing soft-reset trigger. A system status register reports when the soft reset has finished, and software polls it. A read-only revision word carries a major and a minor version number. All registers are 32 bits wide on a simple synchronous port with a byte address. Reads are combinational from the address. Writes take effect at the clock edge on which the write strobe is high.

Top module: `lvl_irq_top`

## Requirements
- R1: After the reset input is released, every source is masked, `irqOut` is 0 and `activeId` is 0. System config (0x10) reads 0, system status (0x14) reads 1, and every mask register reads 0xFFFFFFFF.
- R2: A write to the mask-set register of bank k (0x8C + k*0x20) sets the mask bit of every source whose data bit is 1 and leaves the other mask bits unchanged. Reading this register returns the bank's 32 mask bits, with source 32k+n at bit n.
- R3: A write to the mask-clear register of bank k (0x88 + k*0x20) clears the mask bit of every source whose data bit is 1 and leaves the other mask bits unchanged. Reading this register also returns the bank's mask bits.
- R4: The pending register of bank k (0x98 + k*0x20) reads src & ~mask for the 32 sources of that bank, in the same cycle as the inputs.
- R5: If `irqOut` is 0 and some source is pending at a clock edge, then after that edge `irqOut` is 1 and `activeId` is the lowest pending source number. Both stay unchanged until an acknowledge or a soft reset, whatever the sources do in the meantime. While `irqOut` is 0, `activeId` is 0.
- R6: A write to the control register (0x48) with bit 0 set drops `irqOut` at that edge. A new selection is made at the following edge if a source is pending. A write to 0x48 with bit 0 clear has no effect.
- R7: A write to system config with bit 1 set starts a soft reset that lasts RST_CYCLES cycles. During it, status bit 0 reads 0, config bit 1 reads 1, other register writes are ignored, every mask is set, the request is dropped and autoidle is cleared. Afterwards status bit 0 reads 1 and config bit 1 reads 0.
- R8: Bit 0 of system config is an autoidle bit that reads back the last value written to it. It is cleared by reset and by a soft reset.
- R9: The revision register (0x00) reads REV_MAJOR in bits 7:4 and REV_MINOR in bits 3:0, with the upper bits zero.
- R10: Every other offset reads zero, and writes to it change nothing. This includes unaligned offsets, the control register on read, and bank registers beyond NUM_BANKS.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| src | input | NUM_BANKS*32 | Level-sensitive interrupt sources |
| busWr | input | 1 | Register write strobe |
| busAddr | input | ADDR_W | Register byte address |
| busWdata | input | 32 | Register write data |
| busRdata | output | 32 | Register read data, combinational from busAddr |
| irqOut | output | 1 | Interrupt request to the processor |
| activeId | output | clog2(NUM_BANKS*32) | Number of the presented source |

## Verification
Register reads are combinational, so the bench samples read data shortly after it drives the address, in the low phase of the clock. A write is driven at a falling edge and becomes visible after the next rising edge, where the bench then samples. A pending source raises `irqOut` one rising edge after it appears. An acknowledge drops the request at its own edge, and the new choice appears one edge later; the bench checks both of these cycles separately. After a soft-reset write the bench expects the status bit to read 0 at exactly RST_CYCLES samples and 1 at the next one.

// File: rtl/lvl_irq_pkg.sv
package lvl_irq_pkg;

  // register byte offsets
  localparam logic [7:0] OFS_REV     = 8'h00;
  localparam logic [7:0] OFS_SYSCFG  = 8'h10;
  localparam logic [7:0] OFS_SYSSTAT = 8'h14;
  localparam logic [7:0] OFS_CTRL    = 8'h48;
  localparam logic [7:0] OFS_BANK0   = 8'h88;   // first per-bank register (mask clear)
  localparam int         BANK_STRIDE = 32;      // bytes between banks

  // sub-offsets inside one bank window
  localparam logic [4:0] SUB_MCLR = 5'h00;
  localparam logic [4:0] SUB_MSET = 5'h04;
  localparam logic [4:0] SUB_PEND = 5'h10;

  // strobes from control to datapath
  typedef struct packed {
    logic        maskSet;
    logic        maskClr;
    logic [7:0]  bank;
    logic [31:0] data;
    logic        ack;
    logic        softClr;
  } dpStrobe_t;

endpackage

// File: rtl/lvl_irq_ctl.sv
module lvl_irq_ctl
  import lvl_irq_pkg::*;
#(
  parameter int NUM_BANKS  = 2,
  parameter int ADDR_W     = 10,
  parameter int RST_CYCLES = 4,
  parameter int REV_MAJOR  = 2,
  parameter int REV_MINOR  = 1
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        busWr,
  input  logic [ADDR_W-1:0]           busAddr,
  input  logic [31:0]                 busWdata,
  output logic [31:0]                 busRdata,
  input  logic [NUM_BANKS*32-1:0]     maskVec,
  input  logic [NUM_BANKS*32-1:0]     pendVec,
  output dpStrobe_t                   dpStb,
  output logic                        rstBusy
);

  localparam int BANK_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
  localparam int BANK_SPAN = NUM_BANKS * BANK_STRIDE;
  localparam int CNT_W     = $clog2(RST_CYCLES + 1);

  logic [ADDR_W-1:0] rel;
  logic              inBank;
  logic [BANK_W-1:0] bankSel;
  logic [4:0]        sub;
  logic              wrOk;
  logic              hitCfg;
  logic              startRst;
  logic [CNT_W-1:0]  rstCnt;
  logic              autoIdle;
  logic [31:0]       maskWord;
  logic [31:0]       pendWord;

  // address decode of the banked window
  always_comb begin
    rel     = busAddr - ADDR_W'(OFS_BANK0);
    inBank  = (busAddr >= ADDR_W'(OFS_BANK0)) && (int'(rel) < BANK_SPAN);
    bankSel = rel[BANK_W+4:5];
    sub     = rel[4:0];
  end

  assign wrOk     = busWr && !rstBusy;
  assign hitCfg   = (busAddr == ADDR_W'(OFS_SYSCFG));
  assign startRst = wrOk && hitCfg && busWdata[1];

  // soft reset sequencer and autoidle bit
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rstCnt   <= '0;
      autoIdle <= 1'b0;
    end else if (startRst) begin
      rstCnt   <= CNT_W'(RST_CYCLES);
      autoIdle <= 1'b0;
    end else if (rstCnt != '0) begin
      rstCnt   <= rstCnt - 1'b1;
      autoIdle <= 1'b0;
    end else if (wrOk && hitCfg) begin
      autoIdle <= busWdata[0];
    end
  end

  assign rstBusy = (rstCnt != '0);

  // strobes toward the datapath
  always_comb begin
    dpStb         = '0;
    dpStb.maskClr = wrOk && inBank && (sub == SUB_MCLR);
    dpStb.maskSet = wrOk && inBank && (sub == SUB_MSET);
    dpStb.bank    = 8'(bankSel);
    dpStb.data    = busWdata;
    dpStb.ack     = wrOk && (busAddr == ADDR_W'(OFS_CTRL)) && busWdata[0];
    dpStb.softClr = rstBusy;
  end

  // read mux
  assign maskWord = maskVec[{bankSel, 5'b0} +: 32];
  assign pendWord = pendVec[{bankSel, 5'b0} +: 32];

  always_comb begin
    busRdata = '0;
    if (busAddr == ADDR_W'(OFS_REV)) begin
      busRdata = {24'b0, 4'(REV_MAJOR), 4'(REV_MINOR)};
    end else if (hitCfg) begin
      busRdata = {30'b0, rstBusy, autoIdle};
    end else if (busAddr == ADDR_W'(OFS_SYSSTAT)) begin
      busRdata = {31'b0, !rstBusy};
    end else if (inBank) begin
      if (sub == SUB_MCLR || sub == SUB_MSET) busRdata = maskWord;
      else if (sub == SUB_PEND)               busRdata = pendWord;
    end
  end

endmodule

// File: rtl/lvl_irq_core.sv
module lvl_irq_core
  import lvl_irq_pkg::*;
#(
  parameter int NUM_BANKS = 2
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic [NUM_BANKS*32-1:0]           src,
  input  dpStrobe_t                         dpStb,
  output logic [NUM_BANKS*32-1:0]           maskVec,
  output logic [NUM_BANKS*32-1:0]           pendVec,
  output logic                              irqOut,
  output logic [$clog2(NUM_BANKS*32)-1:0]   activeId
);

  localparam int NUM_SRC = NUM_BANKS * 32;
  localparam int ID_W    = $clog2(NUM_SRC);

  // per-bank mask registers
  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    logic [31:0] maskQ;
    logic        bankHit;

    assign bankHit = (dpStb.bank == 8'(g));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                           maskQ <= '1;
      else if (dpStb.softClr)              maskQ <= '1;
      else if (dpStb.maskSet && bankHit)   maskQ <= maskQ | dpStb.data;
      else if (dpStb.maskClr && bankHit)   maskQ <= maskQ & ~dpStb.data;
    end

    assign maskVec[g*32 +: 32] = maskQ;
  end

  assign pendVec = src & ~maskVec;

  // lowest-numbered pending source
  logic [ID_W-1:0] lowId;
  logic            anyPend;

  always_comb begin
    lowId   = '0;
    anyPend = |pendVec;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (pendVec[i]) lowId = ID_W'(i);
    end
  end

  // active source latch
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqOut   <= 1'b0;
      activeId <= '0;
    end else if (dpStb.softClr || dpStb.ack) begin
      irqOut   <= 1'b0;
      activeId <= '0;
    end else if (!irqOut && anyPend) begin
      irqOut   <= 1'b1;
      activeId <= lowId;
    end
  end

endmodule

// File: rtl/lvl_irq_top.sv
module lvl_irq_top
  import lvl_irq_pkg::*;
#(
  parameter int NUM_BANKS  = 2,
  parameter int ADDR_W     = 10,
  parameter int RST_CYCLES = 4,
  parameter int REV_MAJOR  = 2,
  parameter int REV_MINOR  = 1
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic [NUM_BANKS*32-1:0]           src,
  input  logic                              busWr,
  input  logic [ADDR_W-1:0]                 busAddr,
  input  logic [31:0]                       busWdata,
  output logic [31:0]                       busRdata,
  output logic                              irqOut,
  output logic [$clog2(NUM_BANKS*32)-1:0]   activeId
);

  localparam int NUM_SRC = NUM_BANKS * 32;

  dpStrobe_t          dpStb;
  logic               rstBusy;
  logic [NUM_SRC-1:0] maskVec;
  logic [NUM_SRC-1:0] pendVec;

  lvl_irq_ctl #(
    .NUM_BANKS (NUM_BANKS),
    .ADDR_W    (ADDR_W),
    .RST_CYCLES(RST_CYCLES),
    .REV_MAJOR (REV_MAJOR),
    .REV_MINOR (REV_MINOR)
  ) u_ctl (
    .clk     (clk),
    .rstN    (rstN),
    .busWr   (busWr),
    .busAddr (busAddr),
    .busWdata(busWdata),
    .busRdata(busRdata),
    .maskVec (maskVec),
    .pendVec (pendVec),
    .dpStb   (dpStb),
    .rstBusy (rstBusy)
  );

  lvl_irq_core #(
    .NUM_BANKS(NUM_BANKS)
  ) u_core (
    .clk     (clk),
    .rstN    (rstN),
    .src     (src),
    .dpStb   (dpStb),
    .maskVec (maskVec),
    .pendVec (pendVec),
    .irqOut  (irqOut),
    .activeId(activeId)
  );

endmodule

// File: rtl/lvl_irq_chk.sv
module lvl_irq_chk #(
  parameter int NUM_SRC = 64
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       irqOut,
  input logic [$clog2(NUM_SRC)-1:0] activeId,
  input logic [NUM_SRC-1:0]         pendVec,
  input logic [NUM_SRC-1:0]         maskVec,
  input logic                       ackStb,
  input logic                       rstBusy
);

  logic [NUM_SRC-1:0] prevPend;
  logic [NUM_SRC-1:0] belowMask;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevPend <= '0;
    else       prevPend <= pendVec;
  end

  assign belowMask = (NUM_SRC'(1) << activeId) - NUM_SRC'(1);

  // R5: a new request names a source that was pending and had no lower pending one
  p_pick_lowest_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqOut) |-> (prevPend[activeId] && ((prevPend & belowMask) == '0)));

  // R5: the choice is frozen until acknowledge or soft reset
  p_hold_choice_r5: assert property (@(posedge clk) disable iff (!rstN)
    (irqOut && !ackStb && !rstBusy) |=> (irqOut && $stable(activeId)));

  // R5: no request means id zero
  p_idle_id_r5: assert property (@(posedge clk) disable iff (!rstN)
    !irqOut |-> (activeId == '0));

  // R6: acknowledge drops the request
  p_ack_drop_r6: assert property (@(posedge clk) disable iff (!rstN)
    ackStb |=> !irqOut);

  // R7: a soft reset masks everything and drops the request
  p_soft_mask_r7: assert property (@(posedge clk) disable iff (!rstN)
    rstBusy |=> ((&maskVec) && !irqOut));

endmodule

bind lvl_irq_top lvl_irq_chk #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .irqOut  (irqOut),
  .activeId(activeId),
  .pendVec (pendVec),
  .maskVec (maskVec),
  .ackStb  (dpStb.ack),
  .rstBusy (rstBusy)
);

// File: tb/lvl_irq_top_bench.sv
`timescale 1ns/1ps
module lvl_irq_top_bench;

  localparam int NB  = 2;
  localparam int NS  = NB * 32;
  localparam int RSC = 4;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [NS-1:0] src = '0;
  logic          busWr = 1'b0;
  logic [9:0]    busAddr = '0;
  logic [31:0]   busWdata = '0;
  logic [31:0]   busRdata;
  logic          irqOut;
  logic [5:0]    activeId;

  int total = 0;
  int bad   = 0;

  logic [NS-1:0] mdlMask = '1;
  logic          mdlAuto = 1'b0;

  always #4 clk = ~clk;

  lvl_irq_top #(.NUM_BANKS(NB), .ADDR_W(10), .RST_CYCLES(RSC), .REV_MAJOR(2), .REV_MINOR(1))
    u_lvl_irq_top (
      .clk(clk), .rstN(rstN), .src(src), .busWr(busWr), .busAddr(busAddr),
      .busWdata(busWdata), .busRdata(busRdata), .irqOut(irqOut), .activeId(activeId));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] expRead(input logic [9:0] a);
    logic [NS-1:0] p;
    p = src & ~mdlMask;
    case (a)
      10'h000: return 32'h21;
      10'h010: return {31'b0, mdlAuto};
      10'h014: return 32'h1;
      10'h088, 10'h08C: return mdlMask[31:0];
      10'h0A8, 10'h0AC: return mdlMask[63:32];
      10'h098: return p[31:0];
      10'h0B8: return p[63:32];
      default: return 32'h0;
    endcase
  endfunction

  function automatic int lowest(input logic [NS-1:0] v);
    for (int i = 0; i < NS; i++) if (v[i]) return i;
    return 0;
  endfunction

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    busAddr = a; busWdata = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic rdChk(input string req, input logic [9:0] a);
    busAddr = a;
    #1;
    check(req, busRdata, expRead(a));
  endtask

  task automatic sweep(input string req);
    for (int a = 0; a < 256; a += 4) rdChk(req, 10'(a));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=hung exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 / R9 / R10: reset state and full address map
    src = '1;
    #1;
    check("R1 irqOut", 32'(irqOut), 0);
    check("R1 activeId", 32'(activeId), 0);
    sweep("R1 R9 R10 sweep");
    @(negedge clk);
    check("R1 masked no irq", 32'(irqOut), 0);
    rdChk("R9 revision", 10'h000);

    // R8: autoidle read back
    wr(10'h010, 32'h1); mdlAuto = 1'b1;
    rdChk("R8 autoidle set", 10'h010);
    wr(10'h010, 32'h0); mdlAuto = 1'b0;
    rdChk("R8 autoidle clear", 10'h010);

    // R10: writes to unimplemented offsets change nothing
    wr(10'h0C8, 32'hFFFF_FFFF);
    wr(10'h0CC, 32'h0000_0000);
    wr(10'h089, 32'hFFFF_FFFF);
    wr(10'h004, 32'hFFFF_FFFF);
    wr(10'h098, 32'hFFFF_FFFF);
    sweep("R10 after stray writes");
    check("R10 no irq", 32'(irqOut), 0);

    // R2 / R3: set and clear patterns on each bank
    src = '0;
    for (int b = 0; b < NB; b++) begin
      for (int i = 0; i < 32; i++) begin
        logic [31:0] d;
        d = 32'h9E37_79B9 * 32'(i + 1);
        wr(10'(32'h88 + b * 32), d);
        mdlMask[b*32 +: 32] = mdlMask[b*32 +: 32] & ~d;
        rdChk("R3 clear", 10'(32'h88 + b * 32));
        d = 32'h1 << i;
        wr(10'(32'h8C + b * 32), d);
        mdlMask[b*32 +: 32] = mdlMask[b*32 +: 32] | d;
        rdChk("R2 set", 10'(32'h8C + b * 32));
        wr(10'(32'h8C + b * 32), 32'h0);
        rdChk("R2 zero write", 10'(32'h8C + b * 32));
      end
    end

    // R4: pending view under several source patterns
    for (int p = 0; p < 8; p++) begin
      src = {32'hC3A5_F00F * 32'(p + 3), 32'h7F4A_7C15 * 32'(p + 1)};
      rdChk("R4 pend bank0", 10'h098);
      rdChk("R4 pend bank1", 10'h0B8);
    end
    src = '0;
    @(negedge clk);
    wr(10'h048, 32'h1);
    wr(10'h088, 32'hFFFF_FFFF);
    wr(10'h0A8, 32'hFFFF_FFFF);
    mdlMask = '0;
    @(negedge clk);
    check("R6 idle after clear", 32'(irqOut), 0);

    // R5 / R6: selection, freeze, acknowledge, reselection
    for (int i = 0; i < NS; i++) begin
      int j, lo, hi;
      j = (i * 37 + 11) % NS;
      if (j == i) j = (i + 1) % NS;
      lo = (i < j) ? i : j;
      hi = (i < j) ? j : i;
      src = (NS'(1) << i) | (NS'(1) << j);
      @(negedge clk);
      check("R5 irq up", 32'(irqOut), 1);
      check("R5 lowest id", 32'(activeId), 32'(lo));
      wr(10'h048, 32'h0);
      check("R6 bit0 clear ignored", 32'(irqOut), 1);
      src = NS'(1) << hi;
      @(negedge clk);
      check("R5 frozen id", 32'(activeId), 32'(lo));
      wr(10'h048, 32'h1);
      check("R6 ack drops", 32'(irqOut), 0);
      @(negedge clk);
      check("R6 reselect irq", 32'(irqOut), 1);
      check("R6 reselect id", 32'(activeId), 32'(hi));
      src = '0;
      wr(10'h048, 32'h1);
      check("R6 ack idle", 32'(irqOut), 0);
      @(negedge clk);
      check("R5 no pending", 32'(irqOut), 0);
      check("R5 idle id", 32'(activeId), 0);
    end

    // R7: soft reset handshake
    src = '1;
    wr(10'h010, 32'h1); mdlAuto = 1'b1;
    check("R7 pre irq", 32'(irqOut), 1);
    wr(10'h010, 32'h3);
    busAddr = 10'h014; #1;
    check("R7 busy status s0", busRdata, 0);
    busAddr = 10'h010; #1;
    check("R7 busy config", busRdata, 32'h2);
    wr(10'h088, 32'hFFFF_FFFF);
    busAddr = 10'h014; #1;
    check("R7 busy status s1", busRdata, 0);
    check("R7 irq dropped", 32'(irqOut), 0);
    @(negedge clk);
    busAddr = 10'h014; #1;
    check("R7 busy status s2", busRdata, 0);
    @(negedge clk);
    busAddr = 10'h014; #1;
    check("R7 busy status s3", busRdata, 0);
    @(negedge clk);
    busAddr = 10'h014; #1;
    check("R7 done status", busRdata, 1);
    mdlMask = '1; mdlAuto = 1'b0;
    sweep("R7 R8 after soft reset");
    @(negedge clk);
    check("R7 no irq after", 32'(irqOut), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule